// File: doc/BRIEF.md
# Odd-Even Separating Block Interleaver

This block reorders each frame of information bits before they reach the second component encoder of a turbo encoder. A frame of ROWS×COLS bits is stored in a matrix filled one row after another. It is then emptied one column after another, with the row position advancing fastest. The size of the matrix is the frame length of the code.

Both dimensions must be odd. With that constraint, bits that held odd and even positions in the input strictly alternate at the output. An alternating puncturing pattern applied after the encoders therefore keeps exactly one parity bit for every information bit.

The block has two matrix banks that swap roles. While one bank is being drained, the next frame fills the other bank, so back-to-back frames stream through without gaps. Both sides use valid/ready handshakes. A flag marks the final bit of each frame, and a sideband gives the original input position of each bit leaving the block.

Top module: `oe_interleaver`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The k-th bit accepted in a frame (k counted from 0) is stored at row k / COLS, column k mod COLS.
- R3: The j-th bit delivered in a frame (j counted from 0) comes from row j mod ROWS, column j / ROWS. `out_index` equals that row × COLS + column.
- R4: `out_bit` equals the input bit that was accepted at position `out_index` of the same frame.
- R5: Within a frame, bit 0 of `out_index` changes on every successive delivered bit.
- R6: `out_last` is 1 on the last delivered bit of a frame (j = ROWS·COLS − 1) and 0 on all others.
- R7: With the output stalled, exactly two whole frames are accepted. After that, `in_ready` stays 0 until a bank has been fully drained.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_bit` and `out_index` keep their values into the next cycle.
- R9: ROWS and COLS must both be odd. An even value is rejected at elaboration. Because of this, the final index of a frame (ROWS·COLS − 1) is even, as is the first index 0.
- R10: Frames leave the block in the order in which they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bit present |
| in_ready | output | 1 | Block can accept an input bit |
| in_bit | input | 1 | Input information bit |
| out_valid | output | 1 | Output bit present |
| out_ready | input | 1 | Consumer takes the output bit |
| out_bit | output | 1 | Reordered bit |
| out_index | output | clog2(ROWS·COLS) | Original position of `out_bit` in its frame |
| out_last | output | 1 | Final bit of the frame |

## Verification
The hardest state to reach is both banks full with the reader stalled. Only this state shows the write side stalling and releasing correctly. The bench holds `out_ready` low while streaming input until two frames are accepted and `in_ready` drops. It then drains the banks under pseudo-random valid and ready patterns on both sides. That phase makes the bank handover occur with writes and reads landing in the same cycles, and with stalls in the middle of columns.

// File: rtl/oe_interleaver.sv
module oe_interleaver #(
  parameter int ROWS = 3,
  parameter int COLS = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_bit,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_bit,
  output logic [((ROWS*COLS) > 1 ? $clog2(ROWS*COLS) : 1)-1:0] out_index,
  output logic                 out_last
);
  localparam int N  = ROWS * COLS;
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;

  logic [N-1:0]  mem [2];
  logic [1:0]    full, full_nxt;
  logic          wr_bank, rd_bank;
  logic [IW-1:0] wr_cnt;
  logic [RW-1:0] rd_row;
  logic [CW-1:0] rd_col;

  wire wr_fire = in_valid && in_ready;
  wire rd_fire = out_valid && out_ready;
  wire wr_end  = (wr_cnt == IW'(N - 1));
  wire row_end = (rd_row == RW'(ROWS - 1));
  wire col_end = (rd_col == CW'(COLS - 1));

  assign in_ready  = !full[wr_bank];
  assign out_valid = full[rd_bank];
  assign out_index = IW'(IW'(rd_row) * IW'(COLS)) + IW'(rd_col);
  assign out_bit   = mem[rd_bank][out_index];
  assign out_last  = out_valid && row_end && col_end;

  always_ff @(posedge clk)
    if (wr_fire) mem[wr_bank][wr_cnt] <= in_bit;

  always_comb begin
    full_nxt = full;
    if (wr_fire && wr_end) full_nxt[wr_bank] = 1'b1;
    if (rd_fire && row_end && col_end) full_nxt[rd_bank] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full    <= '0;
      wr_bank <= 1'b0;
      rd_bank <= 1'b0;
      wr_cnt  <= '0;
      rd_row  <= '0;
      rd_col  <= '0;
    end else begin
      full <= full_nxt;
      if (wr_fire) begin
        wr_cnt <= wr_end ? '0 : wr_cnt + 1'b1;
        if (wr_end) wr_bank <= !wr_bank;
      end
      if (rd_fire) begin
        if (!row_end) begin
          rd_row <= rd_row + 1'b1;
        end else begin
          rd_row <= '0;
          if (col_end) begin
            rd_col  <= '0;
            rd_bank <= !rd_bank;
          end else begin
            rd_col <= rd_col + 1'b1;
          end
        end
      end
    end
  end

  initial begin
    AST_ODD_DIMS: assert (ROWS % 2 == 1 && COLS % 2 == 1)
      else $error("ROWS and COLS must both be odd"); // R9
  end

  AST_PARITY_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !out_last) |=> (!out_valid || out_index[0] != $past(out_index[0]))); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_index) && $stable(out_bit))); // R8

  AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_index < IW'(N))); // R3

  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && out_last) |=> (!out_valid || out_index == '0)); // R6
endmodule

// File: tb/sim_oe_interleaver.sv
`timescale 1ns/1ps
module sim_oe_interleaver;
  localparam int R = 3;
  localparam int C = 5;
  localparam int N = R * C;
  localparam int IW = $clog2(N);
  localparam int FRAMES = 6;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n, in_valid, in_bit, out_ready;
  logic in_ready, out_valid, out_bit, out_last;
  logic [IW-1:0] out_index;

  always #2.5 clk = ~clk;

  oe_interleaver #(.ROWS(R), .COLS(C)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit), .out_index(out_index), .out_last(out_last));

  int checks = 0, errors = 0;
  int wf = 0, wk = 0, rf = 0, rj = 0, accepted = 0;
  logic wen = 1'b0;
  logic prev_par = 1'b0;
  logic last_stall = 1'b0;
  logic [IW-1:0] st_idx = '0;
  logic st_bit = 1'b0;
  logic [7:0] lf = 8'hA5;

  function automatic logic data_of(int f, int k);
    return logic'(((f * 13 + k * k + (k >> 1)) ^ (f >> 1)) & 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive();
    in_valid = wen && (wf < FRAMES);
    in_bit   = data_of(wf, wk);
  endtask

  task automatic observe();
    int exp_idx;
    if (out_valid && last_stall) begin
      chk(out_index == st_idx, "R8 index held", int'(out_index), int'(st_idx));
      chk(out_bit == st_bit, "R8 bit held", int'(out_bit), int'(st_bit));
    end
    if (out_valid && out_ready) begin
      exp_idx = (rj % R) * C + rj / R;
      chk(int'(out_index) == exp_idx, "R3 read order", int'(out_index), exp_idx);
      chk(out_bit == data_of(rf, exp_idx), "R2,R4,R10 bit value",
          int'(out_bit), int'(data_of(rf, exp_idx)));
      chk(out_last == (rj == N - 1), "R6 last flag", int'(out_last), int'(rj == N - 1));
      if (rj > 0)
        chk(out_index[0] != prev_par, "R5 parity alternation", int'(out_index[0]), int'(!prev_par));
      if (rj == N - 1)
        chk(int'(out_index) == N - 1 && out_index[0] == 1'b0, "R9 even final index",
            int'(out_index), N - 1);
      prev_par = out_index[0];
      rj++;
      if (rj == N) begin rj = 0; rf++; end
    end
    last_stall = out_valid && !out_ready;
    st_idx = out_index;
    st_bit = out_bit;
    if (in_valid && in_ready) begin
      accepted++;
      wk++;
      if (wk == N) begin wk = 0; wf++; end
    end
  endtask

  initial begin
    int cyc;
    rst_n = 1'b0; in_valid = 1'b0; in_bit = 1'b0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    wen = 1'b1;
    out_ready = 1'b0;
    for (int i = 0; i < 3 * N; i++) begin
      @(negedge clk);
      drive();
      #1;
      observe();
    end
    chk(accepted == 2 * N, "R7 frames accepted while stalled", accepted, 2 * N);
    chk(in_ready == 1'b0, "R7 in_ready with both banks full", int'(in_ready), 0);
    chk(out_valid == 1'b1, "R7 output pending", int'(out_valid), 1);
    chk(out_index == '0, "R3 first index", int'(out_index), 0);

    cyc = 0;
    while (rf < FRAMES && cyc < LIMIT) begin
      @(negedge clk);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      out_ready = lf[0] | lf[3];
      wen = lf[1] | lf[2];
      drive();
      #1;
      observe();
      cyc++;
    end
    if (cyc >= LIMIT) begin
      checks++;
      errors++;
      $display("FAIL watchdog frames_read=%0d expected=%0d", rf, FRAMES);
    end
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R7 all banks drained", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R7 write side free", int'(in_ready), 1);
    chk(wf == FRAMES, "R10 frames written", wf, FRAMES);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule